// File: doc/BRIEF.md
# Maximum-Weight Crossbar Scheduler for Virtual Output Queues

This block is the central scheduler of a small N×N input-queued cell switch in which every input holds a separate queue for each output. One cell for input i and output j sits in queue (i,j), so a head cell that waits for a busy output never holds back cells bound for other outputs. The block tracks how many cells each of the N×N queues holds from per-queue arrival strobes and from its own grants, and it tracks how long the head cell of each non-empty queue has been waiting. Every clock cycle is one cell slot. In each slot the block publishes a crossbar configuration. For each input it gives a valid bit and the output that input may send to. No output is given to two inputs.

The configuration is an exact maximum-weight matching. The block scores every one of the N! one-to-one assignments of inputs to outputs and keeps the one with the largest total weight. Pairs of weight zero are left unmatched. A mode input selects what the weight of a queue is. In one mode it is the queue's length, which favours long queues. In the other mode it is the waiting time of the head cell, which keeps a lightly loaded queue from being starved. A granted pair sends one cell during the slot in which its grant is shown, and its count drops at the end of that slot.

Top module: `voq_mwm_sched`

## Requirements
- R1: While rst_n is low, and in the first slot after it goes high, every grant_valid bit, grant_port and match_weight are zero and all queues are empty.
- R2: An arrival strobe arr[i*N+j] raises the length of queue (i,j) by one at the clock edge that samples it. A pair shown as granted during a slot loses one cell at the edge that ends that slot. An arrival and a departure in the same slot leave the length unchanged.
- R3: A queue that holds 2^CNT_W-1 cells ignores an arrival in a slot in which it is not granted, and its length stays at that value.
- R4: No two inputs with grant_valid set carry the same grant_port value.
- R5: grant_valid[i] is set only when the weight of the pair (i, grant_port[i]) is non-zero. When it is clear, grant_port[i] is zero.
- R6: match_weight equals the largest total weight over all one-to-one assignments of inputs to outputs, and it equals the sum of the weights of the valid grants.
- R7: With mode low, the weight of a pair is the current length of its queue.
- R8: With mode high, the weight of a pair is the age of its head cell. The age is 0 for an empty queue. It is 1 in the slot after a cell enters an empty queue, or after a departure that leaves the queue non-empty. Otherwise it grows by one each slot while the queue is non-empty.
- R9: Among assignments of equal total weight, the scheduler chooses the one whose list of outputs, read from input 0 to input N-1, is lowest in lexicographic order.
- R10: The decision latency is one slot (DECISION_LAT = 1). The grants shown in a slot are computed from the queue state that includes the arrivals, departures and mode sampled at the edge that starts the slot.
- R11: The age of a head cell saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | Weight select: 0 selects queue length, 1 selects head-cell age |
| arr | input | N*N | Arrival strobes. Bit i*N+j is a cell for queue (input i, output j) |
| grant_valid | output | N | Input i is matched in this slot |
| grant_port | output | N*clog2(N) | Output granted to input i, at bits [i*IW +: IW] |
| match_weight | output | CNT_W+clog2(N) | Total weight of the chosen matching |

## Verification
Every result of the block is due in the slot right after the edge that samples its cause. An arrival, a departure or a mode change seen at one edge shows up in grant_valid, grant_port and match_weight just after that same edge. A granted pair's departure is counted at the following edge. The bench keeps a behavioural model that moves at the same rising edge as the design and computes the queue state and the exhaustive best matching. It compares all three outputs at the falling edge, half a slot later, when they have settled and the stimulus for the next edge has not yet been applied. Directed sequences cover tie breaking, saturation of length and age, and starvation under length weighting followed by its relief under age weighting. Random traffic in both modes covers the rest.

// File: rtl/voq_mwm_sched.sv
module voq_mwm_sched #(
  parameter int N = 4,
  parameter int CNT_W = 8,
  localparam int IW = $clog2(N),
  localparam int SUM_W = CNT_W + $clog2(N),
  localparam int DECISION_LAT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic [N*N-1:0]     arr,
  output logic [N-1:0]       grant_valid,
  output logic [N*IW-1:0]    grant_port,
  output logic [SUM_W-1:0]   match_weight
);

  function automatic int fact(input int n);
    int r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  function automatic logic [N*IW-1:0] perm_of(input int k);
    logic [N-1:0] used;
    logic [N*IW-1:0] r;
    int rem, f, sel, cnt;
    used = '0;
    r = '0;
    rem = k;
    for (int i = 0; i < N; i++) begin
      f = fact(N - 1 - i);
      sel = rem / f;
      rem = rem % f;
      cnt = 0;
      for (int j = 0; j < N; j++) begin
        if (!used[j]) begin
          if (cnt == sel) begin
            r[i*IW +: IW] = IW'(j);
            used[j] = 1'b1;
          end
          cnt++;
        end
      end
    end
    return r;
  endfunction

  localparam int NPERM = fact(N);
  localparam int PW = (NPERM > 1) ? $clog2(NPERM) : 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [N*N-1:0][CNT_W-1:0] occ_q, age_q;
  logic [CNT_W-1:0] occ_n [N*N];
  logic [CNT_W-1:0] age_n [N*N];
  logic [CNT_W-1:0] w_n [N*N];
  logic [N-1:0]     gv_q, gv_n;
  logic [N*IW-1:0]  gp_q, gp_n;
  logic [SUM_W-1:0] mw_q;

  always_comb begin
    for (int idx = 0; idx < N*N; idx++) begin
      logic dep;
      dep = gv_q[idx / N] && (gp_q[(idx / N)*IW +: IW] == IW'(idx % N));
      occ_n[idx] = occ_q[idx];
      if (arr[idx] && !dep) begin
        if (occ_q[idx] != CMAX) occ_n[idx] = occ_q[idx] + CNT_W'(1);
      end else if (!arr[idx] && dep) begin
        occ_n[idx] = occ_q[idx] - CNT_W'(1);
      end
      if (occ_n[idx] == '0)        age_n[idx] = '0;
      else if (dep)                age_n[idx] = CNT_W'(1);
      else if (age_q[idx] == CMAX) age_n[idx] = CMAX;
      else                         age_n[idx] = age_q[idx] + CNT_W'(1);
      w_n[idx] = mode ? age_n[idx] : occ_n[idx];
    end
  end

  logic [SUM_W-1:0]  psum [NPERM];
  logic [N*IW-1:0]   pmap [NPERM];

  for (genvar k = 0; k < NPERM; k++) begin : g_perm
    localparam logic [N*IW-1:0] MAP = perm_of(k);
    logic [SUM_W-1:0] s;
    always_comb begin
      s = '0;
      for (int i = 0; i < N; i++)
        s = s + SUM_W'(w_n[i*N + int'(MAP[i*IW +: IW])]);
    end
    assign psum[k] = s;
    assign pmap[k] = MAP;
  end

  logic [PW-1:0]    best;
  logic [SUM_W-1:0] bsum;

  always_comb begin
    best = '0;
    bsum = psum[0];
    for (int k = 1; k < NPERM; k++) begin
      if (psum[k] > bsum) begin
        best = PW'(k);
        bsum = psum[k];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [IW-1:0] j;
      j = pmap[best][i*IW +: IW];
      gv_n[i] = (w_n[i*N + int'(j)] != '0);
      gp_n[i*IW +: IW] = gv_n[i] ? j : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      age_q <= '0;
      gv_q  <= '0;
      gp_q  <= '0;
      mw_q  <= '0;
    end else begin
      for (int idx = 0; idx < N*N; idx++) begin
        occ_q[idx] <= occ_n[idx];
        age_q[idx] <= age_n[idx];
      end
      gv_q <= gv_n;
      gp_q <= gp_n;
      mw_q <= bsum;
    end
  end

  assign grant_valid  = gv_q;
  assign grant_port   = gp_q;
  assign match_weight = mw_q;

endmodule

// File: rtl/voq_mwm_sched_chk.sv
module voq_mwm_sched_chk #(
  parameter int N = 4,
  parameter int CNT_W = 8,
  parameter int LAT = 1,
  localparam int IW = $clog2(N),
  localparam int SUM_W = CNT_W + $clog2(N)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N*N-1:0]            arr,
  input logic [N-1:0]              gv,
  input logic [N*IW-1:0]           gp,
  input logic [SUM_W-1:0]          mw,
  input logic [N*N-1:0][CNT_W-1:0] occ
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic conflict;
  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < N; i++)
      for (int k = i + 1; k < N; k++)
        if (gv[i] && gv[k] && gp[i*IW +: IW] == gp[k*IW +: IW]) conflict = 1'b1;
  end

  a_r4_one_input_per_output: assert property (@(posedge clk) disable iff (!rst_n) !conflict);

  a_r6_weight_zero_iff_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (gv == '0) == (mw == '0));

  a_r10_decision_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (arr != '0) |-> ##LAT (gv != '0));

  for (genvar i = 0; i < N; i++) begin : g_in
    a_r5_grant_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      gv[i] |-> (occ[i*N + int'(gp[i*IW +: IW])] != '0));
    for (genvar j = 0; j < N; j++) begin : g_out
      logic g;
      assign g = gv[i] && (gp[i*IW +: IW] == IW'(j));
      a_r2_arrival_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (arr[i*N+j] && !g && occ[i*N+j] != CMAX) |=> (occ[i*N+j] == $past(occ[i*N+j]) + CNT_W'(1)));
      a_r2_departure_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (g && !arr[i*N+j]) |=> (occ[i*N+j] == $past(occ[i*N+j]) - CNT_W'(1)));
      a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (arr[i*N+j] && !g && occ[i*N+j] == CMAX) |=> (occ[i*N+j] == CMAX));
    end
  end
endmodule

bind voq_mwm_sched voq_mwm_sched_chk #(.N(N), .CNT_W(CNT_W), .LAT(DECISION_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .arr(arr), .gv(grant_valid), .gp(grant_port),
  .mw(match_weight), .occ(occ_q)
);

// File: tb/voq_mwm_sched_bench.sv
`timescale 1ns/1ps
module voq_mwm_sched_bench;
  localparam int N = 4;
  localparam int CW = 4;
  localparam int IW = $clog2(N);
  localparam int SW = CW + $clog2(N);
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [N*N-1:0] arr = '0;
  logic [N-1:0] grant_valid;
  logic [N*IW-1:0] grant_port;
  logic [SW-1:0] match_weight;

  voq_mwm_sched #(.N(N), .CNT_W(CW)) u_voq_mwm_sched (
    .clk(clk), .rst_n(rst_n), .mode(mode), .arr(arr),
    .grant_valid(grant_valid), .grant_port(grant_port), .match_weight(match_weight)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  int m_occ [N][N];
  int m_age [N][N];
  int m_w   [N][N];
  int m_gv  [N];
  int m_gp  [N];
  int m_mw = 0;
  int pm    [N];

  initial begin
    for (int i = 0; i < N; i++) begin
      m_gv[i] = 0; m_gp[i] = 0;
      for (int j = 0; j < N; j++) begin m_occ[i][j] = 0; m_age[i][j] = 0; end
    end
  end

  function automatic bit next_perm();
    int i, j, t, lo, hi;
    i = N - 2;
    while (i >= 0 && pm[i] >= pm[i+1]) i--;
    if (i < 0) return 1'b0;
    j = N - 1;
    while (pm[j] <= pm[i]) j--;
    t = pm[i]; pm[i] = pm[j]; pm[j] = t;
    lo = i + 1; hi = N - 1;
    while (lo < hi) begin t = pm[lo]; pm[lo] = pm[hi]; pm[hi] = t; lo++; hi--; end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_gv[i] = 0; m_gp[i] = 0;
        for (int j = 0; j < N; j++) begin m_occ[i][j] = 0; m_age[i][j] = 0; end
      end
      m_mw = 0;
    end else begin
      int best, s;
      bit more;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          bit dep, a;
          dep = (m_gv[i] != 0) && (m_gp[i] == j);
          a = arr[i*N+j];
          if (a && !dep) begin
            if (m_occ[i][j] < MAXV) m_occ[i][j]++;
          end else if (!a && dep) m_occ[i][j]--;
          if (m_occ[i][j] == 0) m_age[i][j] = 0;
          else if (dep) m_age[i][j] = 1;
          else if (m_age[i][j] < MAXV) m_age[i][j]++;
          m_w[i][j] = mode ? m_age[i][j] : m_occ[i][j];
        end
      for (int k = 0; k < N; k++) pm[k] = k;
      best = -1;
      more = 1'b1;
      while (more) begin
        s = 0;
        for (int k = 0; k < N; k++) s += m_w[k][pm[k]];
        if (s > best) begin
          best = s;
          for (int k = 0; k < N; k++) begin
            m_gv[k] = (m_w[k][pm[k]] != 0) ? 1 : 0;
            m_gp[k] = m_gv[k] ? pm[k] : 0;
          end
        end
        more = next_perm();
      end
      m_mw = best;
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", t, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int ev, ep;
    ev = 0; ep = 0;
    for (int i = 0; i < N; i++) begin
      ev |= m_gv[i] << i;
      ep |= m_gp[i] << (i*IW);
    end
    check(tag, "grant_valid", int'(grant_valid), ev);
    check(tag, "grant_port", int'(grant_port), ep);
    check(tag, "match_weight", int'(match_weight), m_mw);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    arr = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_random(input string t, input int n, input bit dense, input int md);
    tag = t;
    repeat (n) begin
      @(negedge clk);
      arr = dense ? N*N'($urandom | $urandom) : N*N'($urandom & $urandom & $urandom);
      mode = (md == 2) ? 1'($urandom) : 1'(md);
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: single arrival at (2,1) granted in the very next slot
    tag = "R10";
    arr = '0; arr[2*N+1] = 1'b1;
    idle(0);
    @(negedge clk);
    idle(3);
    // R9: four equal weights, lexicographically lowest assignment wins
    tag = "R9";
    arr = '0; arr[0] = 1'b1; arr[1] = 1'b1; arr[N] = 1'b1; arr[N+1] = 1'b1;
    @(negedge clk);
    idle(4);
    // R7: length weighting
    run_random("R7", 300, 1'b1, 0);
    idle(20);
    // R3: all inputs flood output 0, queues saturate
    tag = "R3";
    mode = 1'b0;
    repeat (40) begin
      @(negedge clk);
      arr = '0;
      for (int i = 0; i < N; i++) arr[i*N] = 1'b1;
    end
    idle(70);
    // R11: starvation under length weighting, age saturates, then age weighting
    tag = "R11";
    mode = 1'b0;
    arr = '0; arr[0] = 1'b1; arr[N] = 1'b1;
    @(negedge clk);
    repeat (25) begin arr = '0; arr[0] = 1'b1; @(negedge clk); end
    mode = 1'b1;
    repeat (10) begin arr = '0; arr[0] = 1'b1; @(negedge clk); end
    idle(30);
    // R8: age weighting
    run_random("R8", 300, 1'b1, 1);
    idle(30);
    run_random("R2", 200, 1'b0, 2);
    run_random("R4", 200, 1'b1, 0);
    run_random("R5", 200, 1'b0, 1);
    run_random("R6", 300, 1'b1, 2);
    idle(10);
    // R1: reset in mid-run clears everything
    tag = "R1";
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule